// File: doc/BRIEF.md
# Predicated vector loop sequencer

This block steps a scalar instruction through the elements of a vector. Fetch raises `start_i` once for each instruction and supplies the vector length and two element masks, one for the source side and one for the destination side. The block then runs a source step and a destination step through the vector. It tells the execute stage which element pair to run next, and whether that element's input should read as zero and its result should be written as zero.

While the loop runs, the block holds the program counter. When the loop finishes, it releases the program counter with a one-cycle advance pulse.

When zeroing is off for a side, that side skips masked-off elements. The skip moves one element per clock cycle, and `busy_o` is high while the block is searching. When zeroing is on for a side, that side does not skip. It flags the element as zeroed instead.

After each executed element, the loop either moves both steps forward together or ends. It ends when either side reaches its final element, or when the operation is scalar. A side that skips past the vector length ends the instruction without running another element.

Top module: `vec_loop_seq`

## Requirements
- R1: After reset, both steps are 0 and `busy_o`, `ready_o`, `pc_hold_o` and `pc_adv_o` are all low. `busy_o` and `ready_o` are never high together.
- R2: A start with a vector length of 0 produces one `pc_adv_o` pulse in the next cycle. It executes no element and never raises `busy_o`.
- R3: With source zeroing off, the source step moves past clear source mask bits, where bit i belongs to element i. It moves at most one element per cycle and stops at the vector length. `busy_o` is high for every searching cycle plus one deciding cycle.
- R4: The destination step skips independently of the source step, using the destination mask and the destination zeroing flag.
- R5: With zeroing on for a side, that side never skips. During `ready_o`, that side's zero flag is high exactly when its mask bit at the current step is clear.
- R6: If either step equals the vector length after skipping, both steps return to 0 and `pc_adv_o` pulses. No element is offered.
- R7: On `done_i` during `ready_o`, if the loop is vector and neither step equals the vector length minus 1, both steps increase by 1. `pc_hold_o` stays high and a new search follows.
- R8: Otherwise `done_i` returns both steps to 0, drops `pc_hold_o`, and pulses `pc_adv_o` for exactly one cycle.
- R9: The loop is vector if outputs are vector. It is also vector if inputs are vector, but only when twin predication is set.
- R10: `cr_ok_o` is high during `ready_o` only when the destination element is not zeroed. A zeroed destination suppresses the condition-register update.
- R11: `done_i` outside `ready_o` has no effect on the steps or on `pc_adv_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Setup of a new instruction; all configuration inputs are captured here |
| vl_i | input | 7 | Vector length, 0..MAX_VL |
| src_mask_i | input | 64 | Source predicate, bit i for element i |
| dst_mask_i | input | 64 | Destination predicate, bit i for element i |
| src_zero_i | input | 1 | Source zeroing enable |
| dst_zero_i | input | 1 | Destination zeroing enable |
| twin_pred_i | input | 1 | Twin predication: input vector flag also counts |
| out_vec_i | input | 1 | Output operand is a vector |
| in_vec_i | input | 1 | Input operand is a vector |
| done_i | input | 1 | Execute finished the offered element |
| busy_o | output | 1 | Skip search in progress |
| ready_o | output | 1 | Element pair offered for execution |
| src_step_o | output | 7 | Current source step |
| dst_step_o | output | 7 | Current destination step |
| zero_src_o | output | 1 | Source element reads as zero |
| zero_dst_o | output | 1 | Destination element is written as zero |
| cr_ok_o | output | 1 | Condition-register update permitted for this element |
| pc_hold_o | output | 1 | Loop active, hold program counter |
| pc_adv_o | output | 1 | One-cycle pulse: advance to next instruction |

## Verification
The bench builds the block with its default of MAX_VL = 64, so steps are 7 bits wide and masks are 64 bits wide. This makes the widest case reachable: a full 64-element loop, and a destination mask whose only set bit is bit 63. That mask forces 63 consecutive skip cycles and ends the loop on the last legal step. A mask with no set bits drives a step all the way to the vector length, which is the overrun exit. Twin-predication cases with scalar outputs show the input vector flag taking effect only when twin predication is set.

// File: rtl/vls_pkg.sv
package vls_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SKIP = 2'd1,
    ST_EXEC = 2'd2
  } vls_state_e;

  localparam int unsigned LANES  = 2;
  localparam int unsigned LN_SRC = 0;
  localparam int unsigned LN_DST = 1;
endpackage

// File: rtl/vls_lane.sv
module vls_lane #(
  parameter int unsigned MAX_VL = 64,
  localparam int unsigned STEP_W = $clog2(MAX_VL + 1),
  localparam int unsigned IDX_W  = (MAX_VL > 1) ? $clog2(MAX_VL) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [MAX_VL-1:0] mask_i,
  input  logic              zero_en_i,
  input  logic [STEP_W-1:0] vl_i,
  input  logic              skip_en_i,
  input  logic              inc_i,
  input  logic              clr_i,
  output logic [STEP_W-1:0] step_o,
  output logic              skip_o,
  output logic              end_o,
  output logic              last_o,
  output logic              zero_o
);
  logic [STEP_W-1:0] step_q;
  logic [MAX_VL-1:0] mask_q;
  logic              zero_en_q;
  logic              bit_sel;

  // steps at or beyond MAX_VL see a clear bit
  assign bit_sel = (step_q < STEP_W'(MAX_VL)) ? mask_q[step_q[IDX_W-1:0]] : 1'b0;

  assign end_o  = (step_q == vl_i);
  assign last_o = ((step_q + STEP_W'(1)) == vl_i);
  assign skip_o = !zero_en_q && !bit_sel && !end_o;
  assign zero_o = zero_en_q && !bit_sel;
  assign step_o = step_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q    <= '0;
      mask_q    <= '0;
      zero_en_q <= 1'b0;
    end else begin
      if (load_i) begin
        mask_q    <= mask_i;
        zero_en_q <= zero_en_i;
      end
      if (load_i || clr_i)            step_q <= '0;
      else if (skip_en_i && skip_o)   step_q <= step_q + STEP_W'(1);
      else if (inc_i)                 step_q <= step_q + STEP_W'(1);
    end
  end

  p_no_skip_zeroing_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (skip_en_i && zero_en_q && !load_i && !clr_i) |=> step_q == $past(step_q));
endmodule

// File: rtl/vls_ctrl.sv
module vls_ctrl
  import vls_pkg::*;
#(
  parameter int unsigned MAX_VL = 64,
  localparam int unsigned STEP_W = $clog2(MAX_VL + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              done_i,
  input  logic [STEP_W-1:0] vl_i,
  input  logic              twin_i,
  input  logic              out_vec_i,
  input  logic              in_vec_i,
  input  logic              any_skip_i,
  input  logic              any_end_i,
  input  logic              any_last_i,
  output logic [STEP_W-1:0] vl_o,
  output logic              load_o,
  output logic              skip_en_o,
  output logic              inc_o,
  output logic              clr_o,
  output logic              busy_o,
  output logic              ready_o,
  output logic              hold_o,
  output logic              adv_o
);
  vls_state_e        state_q, state_d;
  logic [STEP_W-1:0] vl_q;
  logic              twin_q, out_vec_q, in_vec_q;
  logic              adv_q, adv_d;
  logic              is_vec;

  assign is_vec = out_vec_q || (twin_q && in_vec_q);

  always_comb begin
    state_d = state_q;
    load_o  = 1'b0;
    inc_o   = 1'b0;
    clr_o   = 1'b0;
    adv_d   = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        if (vl_i == '0) adv_d = 1'b1;
        else begin
          load_o  = 1'b1;
          state_d = ST_SKIP;
        end
      end
      ST_SKIP: if (!any_skip_i) begin
        if (any_end_i) begin
          clr_o   = 1'b1;
          adv_d   = 1'b1;
          state_d = ST_IDLE;
        end else state_d = ST_EXEC;
      end
      ST_EXEC: if (done_i) begin
        if (is_vec && !any_last_i) begin
          inc_o   = 1'b1;
          state_d = ST_SKIP;
        end else begin
          clr_o   = 1'b1;
          adv_d   = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      vl_q      <= '0;
      twin_q    <= 1'b0;
      out_vec_q <= 1'b0;
      in_vec_q  <= 1'b0;
      adv_q     <= 1'b0;
    end else begin
      state_q <= state_d;
      adv_q   <= adv_d;
      if (load_o) begin
        vl_q      <= vl_i;
        twin_q    <= twin_i;
        out_vec_q <= out_vec_i;
        in_vec_q  <= in_vec_i;
      end
    end
  end

  assign vl_o      = vl_q;
  assign skip_en_o = (state_q == ST_SKIP);
  assign busy_o    = (state_q == ST_SKIP);
  assign ready_o   = (state_q == ST_EXEC);
  assign hold_o    = (state_q != ST_IDLE);
  assign adv_o     = adv_q;

  p_vl0_skip_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && start_i && vl_i == '0) |=> (adv_o && !busy_o && !ready_o));
  p_adv_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_o |=> !adv_o);
endmodule

// File: rtl/vec_loop_seq.sv
module vec_loop_seq
  import vls_pkg::*;
#(
  parameter int unsigned MAX_VL = 64,
  localparam int unsigned STEP_W = $clog2(MAX_VL + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [STEP_W-1:0] vl_i,
  input  logic [MAX_VL-1:0] src_mask_i,
  input  logic [MAX_VL-1:0] dst_mask_i,
  input  logic              src_zero_i,
  input  logic              dst_zero_i,
  input  logic              twin_pred_i,
  input  logic              out_vec_i,
  input  logic              in_vec_i,
  input  logic              done_i,
  output logic              busy_o,
  output logic              ready_o,
  output logic [STEP_W-1:0] src_step_o,
  output logic [STEP_W-1:0] dst_step_o,
  output logic              zero_src_o,
  output logic              zero_dst_o,
  output logic              cr_ok_o,
  output logic              pc_hold_o,
  output logic              pc_adv_o
);
  logic [LANES-1:0][MAX_VL-1:0] mask_a;
  logic [LANES-1:0]             zen_a;
  logic [LANES-1:0][STEP_W-1:0] step_a;
  logic [LANES-1:0]             skip_a, end_a, last_a, zero_a;
  logic [STEP_W-1:0]            vl_q;
  logic load, skip_en, inc, clr;

  assign mask_a = {dst_mask_i, src_mask_i};
  assign zen_a  = {dst_zero_i, src_zero_i};

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    vls_lane #(.MAX_VL(MAX_VL)) lane_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .load_i    (load),
      .mask_i    (mask_a[g]),
      .zero_en_i (zen_a[g]),
      .vl_i      (vl_q),
      .skip_en_i (skip_en),
      .inc_i     (inc),
      .clr_i     (clr),
      .step_o    (step_a[g]),
      .skip_o    (skip_a[g]),
      .end_o     (end_a[g]),
      .last_o    (last_a[g]),
      .zero_o    (zero_a[g])
    );
  end

  vls_ctrl #(.MAX_VL(MAX_VL)) ctrl_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .done_i     (done_i),
    .vl_i       (vl_i),
    .twin_i     (twin_pred_i),
    .out_vec_i  (out_vec_i),
    .in_vec_i   (in_vec_i),
    .any_skip_i (|skip_a),
    .any_end_i  (|end_a),
    .any_last_i (|last_a),
    .vl_o       (vl_q),
    .load_o     (load),
    .skip_en_o  (skip_en),
    .inc_o      (inc),
    .clr_o      (clr),
    .busy_o     (busy_o),
    .ready_o    (ready_o),
    .hold_o     (pc_hold_o),
    .adv_o      (pc_adv_o)
  );

  assign src_step_o = step_a[LN_SRC];
  assign dst_step_o = step_a[LN_DST];
  assign zero_src_o = ready_o && zero_a[LN_SRC];
  assign zero_dst_o = ready_o && zero_a[LN_DST];
  assign cr_ok_o    = ready_o && !zero_a[LN_DST];

  p_no_overlap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && ready_o));
  p_skip_stride_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> (src_step_o == $past(src_step_o) || src_step_o == $past(src_step_o) + STEP_W'(1)
                || (src_step_o == '0 && dst_step_o == '0)));
  p_step_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_hold_o |-> (src_step_o <= vl_q && dst_step_o <= vl_q));
  p_lockstep_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && done_i) |=>
      ((src_step_o == $past(src_step_o) + STEP_W'(1) && dst_step_o == $past(dst_step_o) + STEP_W'(1) && !pc_adv_o)
       || (src_step_o == '0 && dst_step_o == '0 && pc_adv_o)));
  p_adv_reset_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_adv_o |-> (src_step_o == '0 && dst_step_o == '0 && !pc_hold_o));
  p_cr_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_dst_o |-> !cr_ok_o);
endmodule

// File: tb/vec_loop_seq_tb_top.sv
module vec_loop_seq_tb_top;
  localparam int unsigned MAX_VL = 64;
  localparam int unsigned STEP_W = 7;

  typedef struct packed {
    logic [6:0]  vl;
    logic [63:0] sm;
    logic [63:0] dm;
    logic sz, dz, tw, ov, iv;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t TBL [NV] = '{
    '{7'd0,  64'hF,                  64'hF,                  1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
    '{7'd4,  64'hF,                  64'hF,                  1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
    '{7'd5,  64'h16,                 64'h1F,                 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
    '{7'd4,  64'h5,                  64'hF,                  1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
    '{7'd4,  64'hF,                  64'hF,                  1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
    '{7'd4,  64'hF,                  64'hF,                  1'b0, 1'b0, 1'b1, 1'b0, 1'b1},
    '{7'd6,  64'h0,                  64'h3F,                 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
    '{7'd64, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
    '{7'd4,  64'hF,                  64'hA,                  1'b0, 1'b1, 1'b0, 1'b1, 1'b0},
    '{7'd64, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}
  };

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0, done_i = 1'b0;
  logic [STEP_W-1:0] vl_i = '0;
  logic [MAX_VL-1:0] src_mask_i = '0, dst_mask_i = '0;
  logic src_zero_i = 1'b0, dst_zero_i = 1'b0, twin_pred_i = 1'b0, out_vec_i = 1'b0, in_vec_i = 1'b0;
  logic busy_o, ready_o, zero_src_o, zero_dst_o, cr_ok_o, pc_hold_o, pc_adv_o;
  logic [STEP_W-1:0] src_step_o, dst_step_o;

  int total = 0, bad = 0, cyc = 0;
  bit finished = 0;

  int exp_s [128], exp_d [128];
  bit exp_zs [128], exp_zd [128];
  int exp_n, exp_busy;

  always #2.5 clk_i = ~clk_i;

  vec_loop_seq #(.MAX_VL(MAX_VL)) dut_i (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      finish_run();
    end
  end

  function automatic bit bt(input logic [63:0] m, input int s);
    return (s < 64) ? m[s] : 1'b0;
  endfunction

  // reference model built from the requirements
  task automatic model(input vec_t v);
    int ms, md, vl, ds, dd;
    bit vec;
    exp_n = 0; exp_busy = 0;
    vl = int'(v.vl);
    if (vl == 0) return;
    ms = 0; md = 0;
    vec = v.ov || (v.tw && v.iv);
    forever begin
      ds = 0; dd = 0;
      if (!v.sz) while (ms != vl && !bt(v.sm, ms)) begin ms++; ds++; end
      if (!v.dz) while (md != vl && !bt(v.dm, md)) begin md++; dd++; end
      exp_busy += ((ds > dd) ? ds : dd) + 1;
      if (ms == vl || md == vl) return;
      exp_s[exp_n] = ms; exp_d[exp_n] = md;
      exp_zs[exp_n] = v.sz && !bt(v.sm, ms);
      exp_zd[exp_n] = v.dz && !bt(v.dm, md);
      exp_n++;
      if (vec && ms != vl - 1 && md != vl - 1) begin ms++; md++; end
      else return;
    end
  endtask

  task automatic run_vec(input int idx);
    vec_t v;
    int k, busy_n, guard;
    bit seen_adv;
    v = TBL[idx];
    model(v);
    @(negedge clk_i);
    vl_i = v.vl; src_mask_i = v.sm; dst_mask_i = v.dm;
    src_zero_i = v.sz; dst_zero_i = v.dz; twin_pred_i = v.tw;
    out_vec_i = v.ov; in_vec_i = v.iv;
    start_i = 1'b1;
    k = 0; busy_n = 0; seen_adv = 0; guard = 0;
    while (!seen_adv && guard < 2000) begin
      @(negedge clk_i);
      start_i = 1'b0;
      guard++;
      if (busy_o) busy_n++;
      if (ready_o) begin
        if (k < exp_n) begin
          chk(src_step_o == STEP_W'(exp_s[k]), "R3 src step", int'(src_step_o), exp_s[k]);
          chk(dst_step_o == STEP_W'(exp_d[k]), "R4 dst step", int'(dst_step_o), exp_d[k]);
          chk(zero_src_o == exp_zs[k], "R5 zero src", int'(zero_src_o), int'(exp_zs[k]));
          chk(zero_dst_o == exp_zd[k], "R5 zero dst", int'(zero_dst_o), int'(exp_zd[k]));
          chk(cr_ok_o == !exp_zd[k], "R10 cr ok", int'(cr_ok_o), int'(!exp_zd[k]));
          chk(pc_hold_o == 1'b1, "R7 hold during element", int'(pc_hold_o), 1);
        end
        k++;
        done_i = 1'b1;
      end else done_i = 1'b0;
      if (pc_adv_o) begin
        seen_adv = 1;
        chk(src_step_o == '0 && dst_step_o == '0, "R8 steps reset",
            int'(src_step_o) + int'(dst_step_o), 0);
        chk(!pc_hold_o, "R8 hold released", int'(pc_hold_o), 0);
      end
    end
    done_i = 1'b0;
    chk(seen_adv, "R8 advance seen", int'(seen_adv), 1);
    chk(k == exp_n, "R7 R9 element count", k, exp_n);
    chk(busy_n == exp_busy, "R3 R6 busy cycles", busy_n, exp_busy);
    @(negedge clk_i);
    chk(!pc_adv_o, "R8 single pulse", int'(pc_adv_o), 0);
  endtask

  initial begin
    #1;
    chk(!busy_o && !ready_o && !pc_hold_o && !pc_adv_o, "R1 reset outputs",
        int'({busy_o, ready_o, pc_hold_o, pc_adv_o}), 0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(src_step_o == '0 && dst_step_o == '0, "R1 reset steps",
        int'(src_step_o) + int'(dst_step_o), 0);
    chk(!busy_o && !ready_o && !pc_hold_o && !pc_adv_o, "R1 idle after reset",
        int'({busy_o, ready_o, pc_hold_o, pc_adv_o}), 0);

    for (int i = 0; i < NV; i++) run_vec(i);

    // R2: vl=0 directed, busy never rises
    @(negedge clk_i);
    vl_i = '0; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(pc_adv_o && !busy_o && !ready_o, "R2 vl zero pulse", int'(pc_adv_o), 1);

    // R11: done while idle is ignored
    @(negedge clk_i);
    done_i = 1'b1;
    @(negedge clk_i);
    done_i = 1'b0;
    chk(!pc_adv_o && src_step_o == '0 && dst_step_o == '0, "R11 stray done",
        int'(pc_adv_o), 0);

    // R11: done while busy skipping is ignored
    @(negedge clk_i);
    vl_i = 7'd8; src_mask_i = 64'h80; dst_mask_i = 64'hFF;
    src_zero_i = 0; dst_zero_i = 0; twin_pred_i = 0; out_vec_i = 1; in_vec_i = 0;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0; done_i = 1'b1;
    @(negedge clk_i);
    @(negedge clk_i);
    done_i = 1'b0;
    chk(busy_o && src_step_o == 7'd2 && !pc_adv_o, "R11 done during skip",
        int'(src_step_o), 2);
    begin
      int g = 0;
      while (!ready_o && g < 50) begin @(negedge clk_i); g++; end
    end
    chk(src_step_o == 7'd7 && dst_step_o == '0, "R3 R4 independent skip",
        int'(src_step_o), 7);
    done_i = 1'b1;
    @(negedge clk_i);
    done_i = 1'b0;
    chk(pc_adv_o, "R8 last source element ends", int'(pc_adv_o), 1);

    repeat (2) @(negedge clk_i);
    finish_run();
  end
endmodule